// File: doc/BRIEF.md
# Canvas Image Address Translator

This block turns a pixel access into a memory address. A request gives a signed column byte offset, a signed row index and a direction (read or write). The translator then applies the canvas set up on its configuration inputs: base address, width in bytes, height in rows, row stride in bytes, a layout code and a four-bit flags word. Each accepted request produces exactly one registered result. The result is either a byte address or an error flag.

The checks run in a fixed way. Each axis is checked on its own and, if its wrap flag is set, folded back into range. The access direction is checked against the permission flags. The layout code is then applied: a plain row-major layout, or one of two tiled layouts in which every tile holds 32 rows stored contiguously. A small controller with two states holds the result until the consumer takes it. In `ST_EMPTY` the block is ready for a request, and an accepted request moves it to `ST_FULL`. In `ST_FULL` it returns to `ST_EMPTY` when the result is taken with no new request, and stays in `ST_FULL` when a new request is accepted in the same cycle. While the consumer stalls it stays in `ST_FULL` and refuses new requests.

Top module: `canvas_xlate`

## Requirements
- R1: With layout code 0, the address is base + row*stride + column.
- R2: With layout code 1 (tile 32 bytes wide, 32 rows tall), the address is base + (row/32)*stride*32 + (column/32)*1024 + (row%32)*32 + column%32.
- R3: With layout code 2 (tile 64 bytes wide, 32 rows tall), the address is base + (row/32)*stride*32 + (column/64)*2048 + (row%32)*64 + column%64.
- R4: When flags bit 2 is set, a row outside 0..height-1 is folded modulo height, so -1 becomes height-1 and height becomes 0.
- R5: When flags bit 3 is set, a column outside 0..width-1 is folded modulo width.
- R6: A coordinate out of range on an axis whose wrap flag is clear gives a result with out_err=1 and out_addr=0.
- R7: Flags bit 0 permits reads (req_write=0) and bit 1 permits writes (req_write=1). A request in a direction that is not permitted gives out_err=1 and out_addr=0.
- R8: Layout code 3 gives out_err=1 and out_addr=0.
- R9: A request accepted at a clock edge has its result on out_valid directly after that edge.
- R10: While out_valid=1 and out_ready=0, out_addr and out_err stay stable, out_valid stays high and req_ready is low.
- R11: After reset, out_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Canvas base byte address |
| cfg_width | input | DW | Canvas width in bytes |
| cfg_height | input | DW | Canvas height in rows |
| cfg_stride | input | DW | Byte distance between rows |
| cfg_mode | input | 2 | Layout code: 0 linear, 1 tile 32x32, 2 tile 64x32 |
| cfg_flags | input | 4 | Bit0 read, bit1 write, bit2 row wrap, bit3 column wrap |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_col | input | CW | Signed column byte offset |
| req_row | input | CW | Signed row index |
| req_write | input | 1 | 1 write, 0 read |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | AW | Translated address, 0 on error |
| out_err | output | 1 | Access rejected |

## Verification
Taking a held result and accepting a new request can happen in the same cycle, which is the `ST_FULL` to `ST_FULL` transition. The bench provokes this by streaming requests back to back with out_ready high, so every result leaves while the next request enters. A scoreboard then judges that each result matches its own request and that none is lost or duplicated. A second collision is a stalled result meeting a waiting request: the bench lowers out_ready for several cycles and checks that the held result is frozen and that req_ready stays low.

// File: rtl/canvas_pkg.sv
package canvas_pkg;
    typedef enum logic [1:0] {
        LAYOUT_LINEAR = 2'd0,
        LAYOUT_T32    = 2'd1,
        LAYOUT_T64    = 2'd2,
        LAYOUT_BAD    = 2'd3
    } layout_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_st_e;

    localparam int FLG_RD     = 0;
    localparam int FLG_WR     = 1;
    localparam int FLG_WRAP_V = 2;
    localparam int FLG_WRAP_H = 3;
    localparam int TILE_ROWS_LG = 5;
endpackage

// File: rtl/canvas_axis_fold.sv
module canvas_axis_fold #(
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic signed [CW-1:0] coord,
    input  logic        [DW-1:0] dim,
    input  logic                 wrap_en,
    output logic        [DW-1:0] folded,
    output logic                 fault
);
    localparam int EW = ((CW > DW) ? CW : DW) + 1;

    logic signed [EW-1:0] c_e;
    logic signed [EW-1:0] d_e;
    logic signed [EW-1:0] rem;
    logic                 in_rng;

    always_comb begin
        c_e    = EW'(coord);
        d_e    = $signed({{(EW-DW){1'b0}}, dim});
        in_rng = (c_e >= 0) && (c_e < d_e);
        rem    = '0;
        if (dim != '0) begin
            rem = c_e % d_e;
            if (rem < 0) rem = rem + d_e;
        end
        if (in_rng) begin
            folded = c_e[DW-1:0];
            fault  = 1'b0;
        end else if (wrap_en && dim != '0) begin
            folded = rem[DW-1:0];
            fault  = 1'b0;
        end else begin
            folded = '0;
            fault  = 1'b1;
        end
    end
endmodule

// File: rtl/canvas_addr_map.sv
module canvas_addr_map
    import canvas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] stride,
    input  logic [DW-1:0] col,
    input  logic [DW-1:0] row,
    input  layout_e       mode,
    output logic [AW-1:0] addr,
    output logic          bad_mode
);
    logic [AW-1:0] tiled [2];
    logic [AW-1:0] band_off;

    assign band_off = (AW'(row >> TILE_ROWS_LG) * AW'(stride)) << TILE_ROWS_LG;

    for (genvar g = 0; g < 2; g++) begin : g_tile
        localparam int TWL = 5 + g;
        logic [AW-1:0] tx, ix, iy;
        assign tx = AW'(col >> TWL);
        assign ix = AW'(col & DW'((1 << TWL) - 1));
        assign iy = AW'(row & DW'((1 << TILE_ROWS_LG) - 1));
        assign tiled[g] = base + band_off + (tx << (TWL + TILE_ROWS_LG))
                        + (iy << TWL) + ix;
    end

    always_comb begin
        bad_mode = 1'b0;
        unique case (mode)
            LAYOUT_LINEAR: addr = base + AW'(row) * AW'(stride) + AW'(col);
            LAYOUT_T32:    addr = tiled[0];
            LAYOUT_T64:    addr = tiled[1];
            default: begin
                addr     = '0;
                bad_mode = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/canvas_xlate.sv
module canvas_xlate
    import canvas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [DW-1:0] cfg_width,
    input  logic [DW-1:0] cfg_height,
    input  logic [DW-1:0] cfg_stride,
    input  logic [1:0]    cfg_mode,
    input  logic [3:0]    cfg_flags,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_col,
    input  logic [CW-1:0] req_row,
    input  logic          req_write,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_err
);
    slot_st_e      st_q, st_d;
    logic          accept;
    logic [DW-1:0] col_f, row_f;
    logic          col_bad, row_bad, perm_bad, mode_bad;
    logic [AW-1:0] map_addr;
    logic          any_bad;

    canvas_axis_fold #(.CW(CW), .DW(DW)) i_col_fold (
        .coord   ($signed(req_col)),
        .dim     (cfg_width),
        .wrap_en (cfg_flags[FLG_WRAP_H]),
        .folded  (col_f),
        .fault   (col_bad)
    );

    canvas_axis_fold #(.CW(CW), .DW(DW)) i_row_fold (
        .coord   ($signed(req_row)),
        .dim     (cfg_height),
        .wrap_en (cfg_flags[FLG_WRAP_V]),
        .folded  (row_f),
        .fault   (row_bad)
    );

    canvas_addr_map #(.AW(AW), .DW(DW)) i_map (
        .base     (cfg_base),
        .stride   (cfg_stride),
        .col      (col_f),
        .row      (row_f),
        .mode     (layout_e'(cfg_mode)),
        .addr     (map_addr),
        .bad_mode (mode_bad)
    );

    assign perm_bad = req_write ? !cfg_flags[FLG_WR] : !cfg_flags[FLG_RD];
    assign any_bad  = col_bad | row_bad | perm_bad | mode_bad;

    assign req_ready = (st_q == ST_EMPTY) || out_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (accept) st_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) st_d = ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_err  <= 1'b0;
        end else if (accept) begin
            out_addr <= any_bad ? '0 : map_addr;
            out_err  <= any_bad;
        end
    end

    assign out_valid = (st_q == ST_FULL);
endmodule

module canvas_xlate_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_err,
    input logic [AW-1:0] out_addr
);
    // R9
    latency_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_err));
    // R10
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !req_ready);
    // R6
    err_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_addr == '0);
    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> req_ready);
endmodule

bind canvas_xlate canvas_xlate_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_err   (out_err),
    .out_addr  (out_addr)
);

// File: tb/test_canvas_xlate.sv
module test_canvas_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [DW-1:0] cfg_width = '0;
    logic [DW-1:0] cfg_height = '0;
    logic [DW-1:0] cfg_stride = '0;
    logic [1:0]    cfg_mode = '0;
    logic [3:0]    cfg_flags = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_col = '0;
    logic [CW-1:0] req_row = '0;
    logic          req_write = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_err;

    typedef struct {
        logic [AW-1:0] addr;
        bit            err;
        string         tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    canvas_xlate #(.AW(AW), .DW(DW), .CW(CW)) i_canvas_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_stride(cfg_stride), .cfg_mode(cfg_mode),
        .cfg_flags(cfg_flags), .req_valid(req_valid), .req_ready(req_ready),
        .req_col(req_col), .req_row(req_row), .req_write(req_write),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_err(out_err)
    );

    function automatic void model(input int col, input int row, input bit wr,
                                  output logic [AW-1:0] a, output bit e);
        longint c, r, w, h, s, tw;
        c = col; r = row; w = cfg_width; h = cfg_height; s = cfg_stride;
        e = 1'b0;
        if (wr && !cfg_flags[1]) e = 1'b1;
        if (!wr && !cfg_flags[0]) e = 1'b1;
        if (cfg_mode == 2'd3) e = 1'b1;
        if (c < 0 || c >= w) begin
            if (cfg_flags[3] && w != 0) c = ((c % w) + w) % w;
            else e = 1'b1;
        end
        if (r < 0 || r >= h) begin
            if (cfg_flags[2] && h != 0) r = ((r % h) + h) % h;
            else e = 1'b1;
        end
        a = '0;
        if (!e) begin
            if (cfg_mode == 2'd0) a = AW'(longint'(cfg_base) + r * s + c);
            else begin
                tw = (cfg_mode == 2'd1) ? 32 : 64;
                a = AW'(longint'(cfg_base) + (r / 32) * s * 32 + (c / tw) * tw * 32
                        + (r % 32) * tw + (c % tw));
            end
        end
    endfunction

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // driver: called just after a rising edge
    task automatic send(input int col, input int row, input bit wr, input string tag);
        item_t it;
        req_col   = CW'(col);
        req_row   = CW'(row);
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        model(col, row, wr, it.addr, it.err);
        it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic setcfg(input int base, input int w, input int h, input int s,
                          input int mode, input int flags);
        cfg_base = AW'(base); cfg_width = DW'(w); cfg_height = DW'(h);
        cfg_stride = DW'(s); cfg_mode = 2'(mode); cfg_flags = 4'(flags);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, $sformatf("R9 unexpected result addr=%h err=%0b expected none",
                                      out_addr, out_err));
            end else begin
                item_t e;
                e = sb.pop_front();
                check(out_addr == e.addr && out_err == e.err,
                      $sformatf("%s addr=%h err=%0b expected addr=%h err=%0b",
                                e.tag, out_addr, out_err, e.addr, e.err));
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "watchdog expired, actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] held_a;
        bit held_e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && req_ready == 1'b1,
              $sformatf("R11 out_valid=%0b req_ready=%0b expected 0 1", out_valid, req_ready));
        rst_n = 1'b1;
        @(posedge clk); #1;

        setcfg(32'h1000, 100, 40, 128, 0, 4'b0011);
        send(5, 3, 1'b0, "R1 linear read");
        send(99, 39, 1'b1, "R1 linear far corner");

        setcfg(32'h8000, 256, 64, 256, 1, 4'b0011);
        send(70, 45, 1'b0, "R2 tile32 inner");
        send(31, 31, 1'b0, "R2 tile32 edge");

        setcfg(32'h8000, 256, 64, 256, 2, 4'b0011);
        send(70, 45, 1'b0, "R3 tile64 inner");
        send(200, 63, 1'b1, "R3 tile64 corner");

        setcfg(32'h1000, 100, 40, 128, 0, 4'b0111);
        send(7, -1, 1'b0, "R4 row -1 wraps");
        send(7, 40, 1'b0, "R4 row height wraps");
        setcfg(32'h1000, 100, 40, 128, 0, 4'b1011);
        send(-3, 2, 1'b0, "R5 col -3 wraps");
        send(250, 2, 1'b0, "R5 col 250 wraps");

        setcfg(32'h1000, 100, 40, 128, 0, 4'b0011);
        send(100, 2, 1'b0, "R6 col out of range");
        send(3, -1, 1'b0, "R6 row out of range");

        setcfg(32'h1000, 100, 40, 128, 0, 4'b0001);
        send(3, 3, 1'b1, "R7 write denied");
        setcfg(32'h1000, 100, 40, 128, 0, 4'b0010);
        send(3, 3, 1'b0, "R7 read denied");
        send(3, 3, 1'b1, "R7 write allowed");

        setcfg(32'h1000, 100, 40, 128, 3, 4'b0011);
        send(3, 3, 1'b0, "R8 bad layout");

        // R9: result present right after the accepting edge
        setcfg(32'h2000, 100, 40, 64, 0, 4'b0011);
        @(posedge clk); #1;
        send(1, 1, 1'b0, "R9 single");
        @(negedge clk);
        check(out_valid == 1'b1, $sformatf("R9 out_valid=%0b expected 1", out_valid));
        repeat (2) @(posedge clk);
        #1;

        // R10: stall holds the result and blocks requests
        out_ready = 1'b0;
        send(9, 2, 1'b0, "R10 held result");
        req_valid = 1'b1;
        req_col = CW'(1); req_row = CW'(1); req_write = 1'b0;
        @(negedge clk);
        held_a = out_addr; held_e = out_err;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid && out_addr == held_a && out_err == held_e && !req_ready,
                  $sformatf("R10 valid=%0b addr=%h ready=%0b expected 1 %h 0",
                            out_valid, out_addr, req_ready, held_a));
        end
        req_valid = 1'b0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(posedge clk); #1;
        send(4, 4, 1'b0, "R10 after stall");

        repeat (4) @(posedge clk);
        check(sb.size() == 0, $sformatf("R9 pending=%0d expected 0", sb.size()));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule